// File: doc/BRIEF.md
# Packed Element Clip Unit

This block clamps every 32-bit element of an XLEN-wide word into a power-of-two range. A 5-bit clip amount `k` picks the range. In signed mode each element is forced into [-2^k, 2^k-1]. In unsigned mode it is forced into [0, 2^k-1], and any negative element becomes zero. XLEN is 32 (one element) or 64 (two elements). Each element is processed on its own.

Operands arrive on a valid/ready input. The result leaves through a one-entry registered output stage, also valid/ready.

- A beat is accepted when `in_valid` and `in_ready` are both high.
- Its result appears on `out_word` with `out_valid` high on the following cycle.
- While the consumer holds `out_ready` low, the output stays frozen and `in_ready` drops, so back-pressure passes straight to the producer.

A sticky `sat_flag` records that some accepted element was clamped. Only the `sat_clr` input clears it.

Top module: `pclip_unit`

## Requirements
- R1: Only bits [4:0] of `in_amt` form the clip amount `k`; bits [7:5] have no effect on the result or on the flag.
- R2: Element i occupies bits [32i+31:32i] of `in_word` and `out_word`. There are XLEN/32 elements, and each is clipped independently of the others.
- R3: With `in_uns`=0, each element taken as signed becomes max(-2^k, min(x, 2^k-1)).
- R4: With `in_uns`=1, a negative element (bit 31 set) becomes 0 and counts as saturated.
- R5: With `in_uns`=1, a non-negative element becomes min(x, 2^k-1).
- R6: An element already inside its range passes unchanged and does not count as saturated.
- R7: `sat_flag` goes to 1 on the clock edge that accepts a beat in which any element was clamped. It then stays at 1 until it is cleared.
- R8: `sat_clr` high clears `sat_flag` at the next edge. If a saturating beat is accepted on that same edge, the flag is set instead, because setting wins.
- R9: `in_ready` = !`out_valid` || `out_ready`. A result appears one cycle after acceptance. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_word` hold steady.
- R10: During and right after reset, `out_valid` and `sat_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat valid |
| in_ready | output | 1 | Unit can take a beat |
| in_word | input | XLEN | Packed source elements |
| in_amt | input | 8 | Clip amount; low 5 bits used |
| in_uns | input | 1 | 0 = signed clip, 1 = unsigned clip |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | XLEN | Clipped elements |
| sat_clr | input | 1 | Clear the saturation flag |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The assertions check the timing rules on every cycle:
- the output stage holds its value under back-pressure;
- every accepted beat produces a result;
- the flag stays sticky, clears on request, and lets a same-cycle set override the clear;
- unsigned results never have bit 31 set.

The exact clamped values need the bench's reference functions, driven by random and directed scenarios. These scenarios cover limits at k=0 and k=31, negative inputs in unsigned mode, one lane saturating while the other does not, and ignored amount bits.

// File: rtl/pclip_pkg.sv
package pclip_pkg;
  localparam int ELEM_W = 32;
  localparam int AMT_W  = 5;
  localparam int AMT_IN_W = 8;
  typedef logic [ELEM_W-1:0] elem_t;
  typedef enum logic {CLIP_SIGNED = 1'b0, CLIP_UNSIGNED = 1'b1} clip_mode_e;
endpackage

// File: rtl/pclip_lane.sv
module pclip_lane
  import pclip_pkg::*;
(
  input  elem_t             din,
  input  logic [AMT_W-1:0]  amt,
  input  logic              uns,
  output elem_t             dout,
  output logic              sat
);
  localparam int WX = ELEM_W + 1;

  logic [WX-1:0]        pow;
  logic signed [WX-1:0] x;
  logic signed [WX-1:0] hi;
  logic signed [WX-1:0] lo;

  always_comb begin
    pow = WX'(1) << amt;
    x   = $signed({din[ELEM_W-1], din});
    hi  = $signed(pow - WX'(1));
    lo  = (clip_mode_e'(uns) == CLIP_UNSIGNED) ? '0 : $signed(-pow);
    if (x > hi) begin
      dout = hi[ELEM_W-1:0];
      sat  = 1'b1;
    end else if (x < lo) begin
      dout = lo[ELEM_W-1:0];
      sat  = 1'b1;
    end else begin
      dout = din;
      sat  = 1'b0;
    end
  end
endmodule

// File: rtl/pclip_sticky.sv
module pclip_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !clr_i |=> flag_o);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !flag_o);
endmodule

// File: rtl/pclip_stage.sv
module pclip_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/pclip_unit.sv
module pclip_unit
  import pclip_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [XLEN-1:0]     in_word,
  input  logic [AMT_IN_W-1:0] in_amt,
  input  logic                in_uns,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [XLEN-1:0]     out_word,
  input  logic                sat_clr,
  output logic                sat_flag
);
  localparam int NLANE = XLEN / ELEM_W;

  logic [XLEN-1:0]  clipped;
  logic [NLANE-1:0] lane_sat;
  logic             accept;
  logic             any_sat;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    pclip_lane u_lane (
      .din  (in_word[i*ELEM_W +: ELEM_W]),
      .amt  (in_amt[AMT_W-1:0]),
      .uns  (in_uns),
      .dout (clipped[i*ELEM_W +: ELEM_W]),
      .sat  (lane_sat[i])
    );

    p_uns_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      accept && in_uns |=> !out_word[i*ELEM_W + ELEM_W - 1]);
  end

  assign accept  = in_valid && in_ready;
  assign any_sat = |lane_sat;

  pclip_stage #(.W(XLEN)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (clipped),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_word)
  );

  pclip_sticky u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (accept && any_sat),
    .clr_i  (sat_clr),
    .flag_o (sat_flag)
  );

  p_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !sat_flag);
endmodule

// File: tb/sim_pclip_unit.sv
`timescale 1ns/1ps
module sim_pclip_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_word = '0;
  logic [7:0]  in_amt = '0;
  logic        in_uns = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_word;
  logic        sat_clr = 1'b0;
  logic        sat_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit exp_flag = 1'b0;

  always #4 clk = ~clk;

  pclip_unit #(.XLEN(64)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_amt(in_amt), .in_uns(in_uns),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .sat_clr(sat_clr), .sat_flag(sat_flag)
  );

  function automatic logic [31:0] ref_clip(input logic [31:0] x, input int k,
                                           input bit uns, output bit s);
    longint v, hi, lo;
    v  = longint'($signed(x));
    hi = (longint'(1) << k) - 1;
    lo = uns ? 0 : -(longint'(1) << k);
    s  = 1'b1;
    if (v > hi)      return hi[31:0];
    else if (v < lo) return lo[31:0];
    s = 1'b0;
    return x;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] w, input logic [7:0] a, input bit uns,
                      input bit clr, input string req);
    logic [63:0] exp;
    bit s0, s1;
    exp[31:0]  = ref_clip(w[31:0],  int'(a[4:0]), uns, s0);
    exp[63:32] = ref_clip(w[63:32], int'(a[4:0]), uns, s1);
    @(negedge clk);
    in_word = w; in_amt = a; in_uns = uns; in_valid = 1'b1;
    out_ready = 1'b1; sat_clr = clr;
    @(posedge clk); #1;
    in_valid = 1'b0; sat_clr = 1'b0;
    exp_flag = (clr ? 1'b0 : exp_flag) | s0 | s1;
    check(req, out_word, exp);
    check("R9 out_valid", 64'(out_valid), 64'd1);
    check("R7 sat_flag", 64'(sat_flag), 64'(exp_flag));
  endtask

  task automatic clear_flag();
    @(negedge clk); sat_clr = 1'b1;
    @(posedge clk); #1; sat_clr = 1'b0;
    exp_flag = 1'b0;
    check("R8 clear", 64'(sat_flag), 64'd0);
  endtask

  initial begin
    #1_200_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] ra;
    repeat (3) @(posedge clk);
    #1;
    check("R10 out_valid", 64'(out_valid), 64'd0);
    check("R10 sat_flag", 64'(sat_flag), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 in_ready", 64'(in_ready), 64'd1);

    // R6: in-range values untouched, flag stays clear
    send({32'd7, 32'hFFFF_FFF9}, 8'd4, 1'b0, 1'b0, "R6 in range");
    check("R6 no flag", 64'(sat_flag), 64'd0);
    // R3 at k=0 and k=31
    send({32'd5, 32'hFFFF_FFF9}, 8'd0, 1'b0, 1'b0, "R3 k0");
    clear_flag();
    send({32'h8000_0000, 32'h7FFF_FFFF}, 8'd31, 1'b0, 1'b0, "R3 k31");
    check("R3 k31 no flag", 64'(sat_flag), 64'd0);
    // R4 / R5
    send({32'hFFFF_FFFF, 32'd100}, 8'd4, 1'b1, 1'b0, "R4 R5 unsigned");
    clear_flag();
    send({32'd3, 32'd100}, 8'd4, 1'b1, 1'b0, "R5 upper clamp");
    clear_flag();
    // R2: one lane saturates, other untouched
    send({32'h0001_0000, 32'd9}, 8'd8, 1'b0, 1'b0, "R2 lanes");
    clear_flag();
    // R1: upper amount bits ignored
    send({32'd1000, 32'hFFFF_F000}, 8'hE6, 1'b0, 1'b0, "R1 amt 0xE6");
    send({32'd1000, 32'hFFFF_F000}, 8'h06, 1'b0, 1'b0, "R1 amt 0x06");
    // R8: set wins over simultaneous clear
    send({32'd1000, 32'd0}, 8'd2, 1'b0, 1'b1, "R8 set wins");
    check("R8 set wins flag", 64'(sat_flag), 64'd1);
    clear_flag();

    // R9: back-pressure
    @(negedge clk); out_ready = 1'b0;
    in_word = {32'd50, 32'd60}; in_amt = 8'd3; in_uns = 1'b0; in_valid = 1'b1;
    @(posedge clk); #1;
    check("R9 first result", out_word, {32'd7, 32'd7});
    check("R9 in_ready low", 64'(in_ready), 64'd0);
    exp_flag = 1'b1;
    @(negedge clk); in_word = {32'd1, 32'd2};
    @(posedge clk); #1;
    check("R9 hold", out_word, {32'd7, 32'd7});
    check("R9 hold valid", 64'(out_valid), 64'd1);
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check("R9 second result", out_word, {32'd1, 32'd2});
    @(posedge clk); #1;
    check("R9 drain", 64'(out_valid), 64'd0);
    check("R7 flag kept", 64'(sat_flag), 64'd1);

    ra = 64'($urandom(32'd7));
    for (int i = 0; i < 400; i++) begin
      logic [63:0] w;
      logic [7:0] a;
      bit u;
      w = {$urandom(), $urandom()};
      if (i % 3 == 0) w = {32'($signed(w[63:48])), 32'($signed(w[15:0]))};
      a = 8'($urandom());
      u = 1'($urandom());
      send(w, a, u, ($urandom() % 8) == 0, u ? "R5 random" : "R3 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule